// File: doc/BRIEF.md
# Bicubic scaler weight generator

This block turns one phase weight into the four filter taps that a resampler uses for the source pixels at relative positions -1, 0, +1 and +2. The phase weight runs from 0 to 512. A weight of 512 puts everything on pixel 0, 256 splits it evenly between pixels 0 and +1, and 0 puts everything on pixel +1. A sharpness setting picks the kernel. Setting 0 gives a nearest-neighbour snap, setting 1 gives a plain linear split, and settings 2 and above evaluate a cubic convolution kernel in signed 15.16 fixed point.

The four taps and a source step offset are packed into two coefficient words for a resampler lookup table. A caller pulses `start` with the weight, sharpness and offset. It collects both words when `done` pulses. The cubic kernel runs one tap at a time over a single shared multiplier. The two snap/split modes finish almost at once.

Top module: `cubic_wgen`

## Requirements
- R1: A weight above 512 behaves exactly like a weight of 512. This holds in every sharpness mode.
- R2: At sharpness 0 the clamped weight w becomes 512 if it is at least 256, and 0 otherwise. The taps (t0, t1, t2, t3) are then (0, w, 512-w, 0).
- R3: At sharpness 1 the taps are (0, w, 512-w, 0), using the clamped weight without snapping.
- R4: At sharpness s of 2 or more, the kernel parameter is a = -8192·s in 15.16, which is -s/8. With w' = 512 - w, tap k uses the distance x = p_k·128, where p = (512+w', w', 512-w', 1024-w') for k = 0..3. The kernel is (a+2)x³ - (a+3)x² + 1 for x ≤ 1.0, and a(x³ - 5x² + 8x - 4) for 1.0 < x ≤ 2.0. Every fixed-point product is the full 64-bit product shifted right arithmetically by 16.
- R5: Each cubic tap is (512·k + 32768) shifted right arithmetically by 16, where k is the kernel value in 15.16. This rounds half toward +infinity. The result is then clamped to -1024..1023.
- R6: word0 holds t1 in bits [26:16] and t0 in bits [10:0]. word1 holds t3 in bits [26:16], t2 in bits [10:0] and the 4-bit offset in bits [31:28]. Taps are 11-bit two's complement, and every other bit is zero.
- R7: `done` is high for exactly one cycle. For sharpness 0 or 1 it rises on the 1st rising edge after the edge that accepted `start`. For sharpness 2 or more it rises on the 21st.
- R8: A `start` seen while a job is in flight is ignored. Inputs that change after acceptance do not alter the job's result.
- R9: After reset, `done` and both words are 0. The words hold their last result until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new tap set; taken only while idle |
| weight_in | input | 12 | Phase weight, clamped to 512 |
| sharp_in | input | 6 | Sharpness setting |
| ofs_in | input | 4 | Source step offset placed in word1 |
| word0 | output | 32 | Packed taps t1 (upper) and t0 (lower) |
| word1 | output | 32 | Packed taps t3 (upper), t2 (lower) and offset |
| done | output | 1 | One-cycle strobe when both words are new |

## Verification
A job started in snap or split mode produces both words and `done` one edge after the accepting edge. A cubic job produces them 21 edges after it. The bench keeps a behavioural model that counts these edges from the acceptance it computes itself. Each falling edge then compares `done` and both words against the model, so a result that arrives a cycle early or late, or that changes between strobes, is caught in the cycle where it happens. Extra `start` pulses and changing inputs during a job check that nothing moves the countdown or the result.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    localparam int FRAC   = 16;
    localparam int UNITY  = 512;
    localparam int WC_W   = $clog2(UNITY) + 1;
    localparam int POS_W  = WC_W + 1;
    localparam int XSH    = FRAC - $clog2(UNITY);
    localparam int COEF_W = 11;
    localparam int COEF_MAX = (1 << (COEF_W - 1)) - 1;
    localparam int COEF_MIN = -(1 << (COEF_W - 1));

    typedef logic signed [31:0]       fx_t;
    typedef logic [WC_W-1:0]          wc_t;
    typedef logic signed [COEF_W-1:0] tap_t;
    typedef tap_t [3:0]               tapvec_t;

    localparam fx_t ONE_FX = fx_t'(1 << FRAC);
    localparam fx_t A_STEP = fx_t'(-(1 << (FRAC - 3)));

    typedef enum logic [2:0] {
        ST_IDLE, ST_SQ, ST_CU, ST_P, ST_Q, ST_FIN, ST_EMIT
    } eng_st_e;

    function automatic fx_t fx_mul(fx_t a, fx_t b);
        return fx_t'((64'(a) * 64'(b)) >>> FRAC);
    endfunction

    function automatic tap_t fx_quant(fx_t r);
        logic signed [63:0] t;
        t = ((64'(r) <<< $clog2(UNITY)) + 64'sd32768) >>> FRAC;
        if (t > 64'(COEF_MAX))      t = 64'(COEF_MAX);
        else if (t < 64'(COEF_MIN)) t = 64'(COEF_MIN);
        return tap_t'(t);
    endfunction

endpackage

// File: rtl/cwg_front.sv
module cwg_front
    import cwg_pkg::*;
#(
    parameter int WT_W = 12,
    parameter int SH_W = 6
) (
    input  logic [WT_W-1:0] weight_in,
    input  logic [SH_W-1:0] sharp_in,
    output wc_t             wp,
    output tapvec_t         bil_taps,
    output logic            cubic,
    output fx_t             a_par
);
    wc_t wc;
    wc_t ws;

    always_comb begin
        wc = (weight_in > WT_W'(UNITY)) ? wc_t'(UNITY) : wc_t'(weight_in);
        if (sharp_in == '0)
            ws = (wc >= wc_t'(UNITY / 2)) ? wc_t'(UNITY) : '0;
        else
            ws = wc;
        bil_taps[0] = '0;
        bil_taps[1] = tap_t'({1'b0, ws});
        bil_taps[2] = tap_t'(UNITY) - tap_t'({1'b0, ws});
        bil_taps[3] = '0;
        wp    = wc_t'(UNITY) - wc;
        cubic = (sharp_in >= SH_W'(2));
        a_par = A_STEP * fx_t'(sharp_in);
    end
endmodule

// File: rtl/cwg_engine.sv
module cwg_engine
    import cwg_pkg::*;
#(
    parameter int OFS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  wc_t              wp_in,
    input  tapvec_t          bil_in,
    input  logic             cubic_in,
    input  fx_t              a_in,
    input  logic [OFS_W-1:0] ofs_in,
    output tapvec_t          taps,
    output logic [OFS_W-1:0] ofs_out,
    output logic             tap_vld,
    output logic             busy
);
    eng_st_e          st;
    logic [1:0]       idx;
    fx_t              a_r, x2_r, x3_r, p_r, q_r;
    wc_t              wp_r;
    tapvec_t          taps_r;
    logic [OFS_W-1:0] ofs_r;

    logic [POS_W-1:0] pos;
    fx_t              x, ma, mb, prod, r_fin;
    logic             near;

    always_comb begin
        unique case (idx)
            2'd0:    pos = POS_W'(UNITY) + {1'b0, wp_r};
            2'd1:    pos = {1'b0, wp_r};
            2'd2:    pos = POS_W'(UNITY) - {1'b0, wp_r};
            default: pos = POS_W'(2 * UNITY) - {1'b0, wp_r};
        endcase
        x    = fx_t'(pos) <<< XSH;
        near = (x <= ONE_FX);
        ma   = '0;
        mb   = '0;
        unique case (st)
            ST_SQ: begin ma = x; mb = x; end
            ST_CU: begin ma = x; mb = x2_r; end
            ST_P: begin
                if (near) begin
                    ma = a_r + (ONE_FX <<< 1);
                    mb = x3_r;
                end else begin
                    ma = a_r;
                    mb = x3_r - (x2_r * fx_t'(5)) + (x <<< 3) - (ONE_FX <<< 2);
                end
            end
            ST_Q: begin ma = a_r + (ONE_FX * fx_t'(3)); mb = x2_r; end
            default: ;
        endcase
        prod  = fx_mul(ma, mb);
        r_fin = near ? (p_r - q_r + ONE_FX) : p_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            a_r    <= '0;
            wp_r   <= '0;
            x2_r   <= '0;
            x3_r   <= '0;
            p_r    <= '0;
            q_r    <= '0;
            taps_r <= '0;
            ofs_r  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    a_r   <= a_in;
                    wp_r  <= wp_in;
                    ofs_r <= ofs_in;
                    idx   <= '0;
                    if (cubic_in) begin
                        st <= ST_SQ;
                    end else begin
                        taps_r <= bil_in;
                        st     <= ST_EMIT;
                    end
                end
                ST_SQ: begin x2_r <= prod; st <= ST_CU; end
                ST_CU: begin x3_r <= prod; st <= ST_P;  end
                ST_P:  begin p_r  <= prod; st <= ST_Q;  end
                ST_Q:  begin q_r  <= near ? prod : '0; st <= ST_FIN; end
                ST_FIN: begin
                    taps_r[idx] <= fx_quant(r_fin);
                    idx         <= idx + 2'd1;
                    st          <= (idx == 2'd3) ? ST_EMIT : ST_SQ;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign taps    = taps_r;
    assign ofs_out = ofs_r;
    assign tap_vld = (st == ST_EMIT);
    assign busy    = (st != ST_IDLE);
endmodule

// File: rtl/cwg_pack.sv
module cwg_pack
    import cwg_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int HI_LSB  = 16,
    parameter int OFS_LSB = 28,
    parameter int OFS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  tapvec_t           taps,
    input  logic [OFS_W-1:0]  ofs,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic              done
);
    for (genvar k = 0; k < 2; k++) begin : g_word
        logic [WORD_W-1:0] nx;
        logic [WORD_W-1:0] wq;
        always_comb begin
            nx = '0;
            nx[COEF_W-1:0]        = taps[2*k];
            nx[HI_LSB +: COEF_W]  = taps[2*k+1];
            if (k == 1) nx[OFS_LSB +: OFS_W] = ofs;
        end
        always_ff @(posedge clk) begin
            if (rst)       wq <= '0;
            else if (load) wq <= nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= load;
    end

    assign word0 = g_word[0].wq;
    assign word1 = g_word[1].wq;
endmodule

// File: rtl/cubic_wgen.sv
module cubic_wgen
    import cwg_pkg::*;
#(
    parameter int WT_W    = 12,
    parameter int SH_W    = 6,
    parameter int OFS_W   = 4,
    parameter int WORD_W  = 32,
    parameter int HI_LSB  = 16,
    parameter int OFS_LSB = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WT_W-1:0]   weight_in,
    input  logic [SH_W-1:0]   sharp_in,
    input  logic [OFS_W-1:0]  ofs_in,
    output logic [WORD_W-1:0] word0,
    output logic [WORD_W-1:0] word1,
    output logic              done
);
    wc_t              f_wp;
    tapvec_t          f_bil;
    logic             f_cubic;
    fx_t              f_a;
    tapvec_t          e_taps;
    logic [OFS_W-1:0] e_ofs;
    logic             e_vld;
    logic             eng_busy;

    cwg_front #(.WT_W(WT_W), .SH_W(SH_W)) u_front (
        .weight_in (weight_in),
        .sharp_in  (sharp_in),
        .wp        (f_wp),
        .bil_taps  (f_bil),
        .cubic     (f_cubic),
        .a_par     (f_a)
    );

    cwg_engine #(.OFS_W(OFS_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wp_in    (f_wp),
        .bil_in   (f_bil),
        .cubic_in (f_cubic),
        .a_in     (f_a),
        .ofs_in   (ofs_in),
        .taps     (e_taps),
        .ofs_out  (e_ofs),
        .tap_vld  (e_vld),
        .busy     (eng_busy)
    );

    cwg_pack #(.WORD_W(WORD_W), .HI_LSB(HI_LSB), .OFS_LSB(OFS_LSB), .OFS_W(OFS_W)) u_pack (
        .clk   (clk),
        .rst   (rst),
        .load  (e_vld),
        .taps  (e_taps),
        .ofs   (e_ofs),
        .word0 (word0),
        .word1 (word1),
        .done  (done)
    );
endmodule

// File: rtl/cwg_checker.sv
module cwg_checker
    import cwg_pkg::*;
#(
    parameter int SH_W    = 6,
    parameter int OFS_W   = 4,
    parameter int WORD_W  = 32,
    parameter int HI_LSB  = 16,
    parameter int OFS_LSB = 28
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [SH_W-1:0]   sharp_in,
    input logic [OFS_W-1:0]  ofs_in,
    input logic [WORD_W-1:0] word0,
    input logic [WORD_W-1:0] word1,
    input logic              done,
    input logic              busy
);
    localparam logic [WORD_W-1:0] M_LO  = (WORD_W'(1) << COEF_W) - WORD_W'(1);
    localparam logic [WORD_W-1:0] M_W0  = M_LO | (M_LO << HI_LSB);
    localparam logic [WORD_W-1:0] M_W1  = M_W0 | (((WORD_W'(1) << OFS_W) - WORD_W'(1)) << OFS_LSB);

    logic [SH_W-1:0]  job_s;
    logic [OFS_W-1:0] job_o;
    logic signed [COEF_W-1:0] lo0, hi0, lo1, hi1;

    assign lo0 = word0[COEF_W-1:0];
    assign hi0 = word0[HI_LSB +: COEF_W];
    assign lo1 = word1[COEF_W-1:0];
    assign hi1 = word1[HI_LSB +: COEF_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            job_s <= '0;
            job_o <= '0;
        end else if (start && !busy) begin
            job_s <= sharp_in;
            job_o <= ofs_in;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R7
    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(word0) && $stable(word1))); // R9
    AST_NEAR_SNAP: assert property (@(posedge clk) disable iff (rst)
        (done && job_s == '0) |-> (lo0 == '0 && hi1 == '0 &&
            ((int'(hi0) == UNITY && lo1 == '0) || (hi0 == '0 && int'(lo1) == UNITY)))); // R2
    AST_BIL_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (done && job_s == SH_W'(1)) |-> (lo0 == '0 && hi1 == '0 &&
            int'(hi0) + int'(lo1) == UNITY)); // R3
    AST_OFS_FIELD: assert property (@(posedge clk) disable iff (rst)
        done |-> (word1[OFS_LSB +: OFS_W] == job_o)); // R6
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((word0 & ~M_W0) == '0) && ((word1 & ~M_W1) == '0)); // R6
endmodule

bind cubic_wgen cwg_checker #(
    .SH_W(SH_W), .OFS_W(OFS_W), .WORD_W(WORD_W), .HI_LSB(HI_LSB), .OFS_LSB(OFS_LSB)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sharp_in (sharp_in),
    .ofs_in   (ofs_in),
    .word0    (word0),
    .word1    (word1),
    .done     (done),
    .busy     (eng_busy)
);

// File: tb/test_cubic_wgen.sv
module test_cubic_wgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] weight_in = '0;
    logic [5:0]  sharp_in = '0;
    logic [3:0]  ofs_in = '0;
    logic [31:0] word0, word1;
    logic        done;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "R9";

    bit          m_busy = 0;
    bit          m_done = 0;
    int          m_cnt = 0;
    logic [31:0] m_w0 = '0, m_w1 = '0, p_w0 = '0, p_w1 = '0;

    always #5 clk = ~clk;

    cubic_wgen i_cubic_wgen (
        .clk(clk), .rst(rst), .start(start), .weight_in(weight_in),
        .sharp_in(sharp_in), .ofs_in(ofs_in), .word0(word0), .word1(word1), .done(done)
    );

    function automatic longint fm(longint a, longint b);
        return (a * b) >>> 16;
    endfunction

    function automatic longint cubic_tap(longint a, longint p);
        longint x, x2, x3, r, t;
        x  = p * 128;
        x2 = fm(x, x);
        x3 = fm(x, x2);
        if (x <= 65536)       r = fm(a + 131072, x3) - fm(a + 196608, x2) + 65536;
        else if (x <= 131072) r = fm(a, x3 - 5 * x2 + 8 * x - 262144);
        else                  r = 0;
        t = (512 * r + 32768) >>> 16;
        if (t > 1023) t = 1023;
        if (t < -1024) t = -1024;
        return t;
    endfunction

    task automatic predict(int w, int s, int o);
        longint t[4];
        longint a, wp;
        int wc;
        wc = (w > 512) ? 512 : w;
        if (s < 2) begin
            if (s == 0) wc = (wc >= 256) ? 512 : 0;
            t[0] = 0; t[1] = wc; t[2] = 512 - wc; t[3] = 0;
        end else begin
            a  = -8192 * s;
            wp = 512 - wc;
            t[0] = cubic_tap(a, 512 + wp);
            t[1] = cubic_tap(a, wp);
            t[2] = cubic_tap(a, 512 - wp);
            t[3] = cubic_tap(a, 1024 - wp);
        end
        p_w0 = (32'(t[1] & 'h7FF) << 16) | 32'(t[0] & 'h7FF);
        p_w1 = (32'(o) << 28) | (32'(t[3] & 'h7FF) << 16) | 32'(t[2] & 'h7FF);
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_w0 = '0; m_w1 = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1; m_w0 = p_w0; m_w1 = p_w1;
                end
            end else if (start) begin
                predict(int'(weight_in), int'(sharp_in), int'(ofs_in));
                m_busy = 1;
                m_cnt  = (sharp_in < 2) ? 1 : 21;
            end
        end
    end

    // comparison against the model on every falling edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R7 done actual=%0b expected=%0b at cycle %0d", done, m_done, cyc);
            end
            checks++;
            if (word0 !== m_w0 || word1 !== m_w1) begin
                errors++;
                $display("FAIL %s words actual=%h_%h expected=%h_%h at cycle %0d",
                         cur_tag, word1, word0, m_w1, m_w0, cyc);
            end
        end
        if (cyc > 20000) begin
            errors++;
            $display("FAIL R7 watchdog actual=%0d cycles expected=done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_job(string tag, int w, int s, int o, bit extra);
        @(negedge clk);
        cur_tag   = tag;
        weight_in = 12'(w);
        sharp_in  = 6'(s);
        ofs_in    = 4'(o);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) begin
            weight_in = 12'(cyc * 37);
            sharp_in  = 6'(cyc % 33);
            ofs_in    = 4'(cyc);
            start     = extra && m_busy && (cyc % 3 == 0);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || word0 !== '0 || word1 !== '0) begin
            errors++;
            $display("FAIL R9 reset actual=%b/%h/%h expected=0/0/0", done, word0, word1);
        end
        rst = 1'b0;
        run_job("R2", 300, 0, 1, 0);
        run_job("R2", 255, 0, 2, 0);
        run_job("R2", 256, 0, 3, 0);
        run_job("R3", 100, 1, 0, 0);
        run_job("R3", 512, 1, 5, 0);
        run_job("R1", 1000, 1, 6, 0);
        run_job("R1", 4095, 0, 7, 0);
        run_job("R4", 512, 8, 1, 0);
        run_job("R4", 256, 8, 2, 0);
        run_job("R4", 100, 8, 3, 0);
        run_job("R5", 0, 2, 4, 0);
        run_job("R5", 384, 32, 15, 0);
        run_job("R5", 37, 20, 9, 0);
        run_job("R1", 3000, 12, 8, 0);
        run_job("R6", 200, 16, 10, 0);
        run_job("R8", 140, 24, 11, 1);
        run_job("R8", 50, 1, 12, 1);
        run_job("R7", 480, 3, 13, 0);
        run_job("R7", 20, 0, 14, 0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule